// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel data buses, called A and B, each presented as a separate input, output and output-enable triple. Each transfer direction has its own capture register. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. Each register loads on the rising edge of its own capture strobe. The strobes are level signals sampled on the system clock. A rise is a cycle in which the strobe is high after a cycle in which it was low.

Each side's output is chosen by its own select. It carries either the live value of the opposite bus or the value held in the register that feeds that side. An active-low output enable and a direction input request which side, if any, is driven. A small drive-mode state machine turns that request into the two output-enable signals. The states are ISOLATE (nothing driven), TO_B (B side driven) and TO_A (A side driven). The named transitions are:

- `enable_b`: ISOLATE to TO_B.
- `enable_a`: ISOLATE to TO_A.
- `release`: any drive state to ISOLATE when the enable is removed.
- `turnaround`: TO_A to ISOLATE or TO_B to ISOLATE, taken when the opposite direction is requested. This makes a direct swap break before make.
- `hold`: the current state is kept.

Capture does not depend on the drive state, so data can be stored while both sides are isolated. A parameter chooses between plain and complementing data paths.

Top module: `reg_bus_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both capture registers and both strobe histories to zero and puts the drive state in ISOLATE, so both enables are low in the cycle after reset.
- R2: The A-to-B register loads `a_in` at a clock edge where `cpab` is 1 and was 0 at the previous edge. At every other edge it holds, so keeping `cpab` high does not load again.
- R3: The B-to-A register loads `b_in` at a clock edge where `cpba` is 1 and was 0 at the previous edge. At every other edge it holds.
- R4: Capture ignores `oe_n` and `dir`. Both registers may load at the same edge, including while both sides are isolated.
- R5: The enables follow the request sampled at the previous edge. `oe_n`=1 gives both low. `oe_n`=0 with `dir`=1 requests `b_oe`. `oe_n`=0 with `dir`=0 requests `a_oe`.
- R6: `a_oe` and `b_oe` are never high together. A request for the opposite direction while one side is driven gives exactly one cycle with both low before the new side is enabled.
- R7: While `b_oe` is high, `b_out` is the current `a_in` when `sab`=0 and the A-to-B register when `sab`=1. The selected value passes through the same cycle.
- R8: While `a_oe` is high, `a_out` is the current `b_in` when `sba`=0 and the B-to-A register when `sba`=1. The selected value passes through the same cycle.
- R9: With `INVERT`=1, every bit of both the live and the stored paths is complemented. With `INVERT`=0, data passes unchanged. Capture always stores the bus value as seen.
- R10: An output whose enable is low reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable request |
| dir | input | 1 | Direction request: 1 drives B, 0 drives A |
| cpab | input | 1 | Capture strobe for the A-to-B register |
| cpba | input | 1 | Capture strobe for the B-to-A register |
| sab | input | 1 | B output source: 0 live A, 1 stored A-to-B |
| sba | input | 1 | A output source: 0 live B, 1 stored B-to-A |
| a_in | input | WIDTH | Value present on bus A |
| b_in | input | WIDTH | Value present on bus B |
| a_out | output | WIDTH | Data to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | WIDTH | Data to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
A capture edge can fall in the same cycle as an output that reads the register being loaded. It can also fall in the same cycle as a direction turnaround. The bench sets up both cases: it raises a strobe while the stored source is selected, it raises both strobes during isolation, and it flips `dir` every cycle with the output enabled. A behavioural model predicts the result, judging that the output shows the old stored value until the edge and the new value after it, and that the turnaround gap leaves both enables low for exactly one cycle. Sixteen blocks of cycles cover every setting of the four controls, and a random run follows them, with a plain and a complementing instance compared side by side.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
    typedef enum logic [1:0] {
        DRV_ISOLATE = 2'd0,
        DRV_TO_B    = 2'd1,
        DRV_TO_A    = 2'd2
    } drive_e;
endpackage

// File: rtl/xcvr_rise_capture.sv
`timescale 1ns/1ps
// Capture register loaded on a 0->1 transition of its strobe.
module xcvr_rise_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic strobe_d;
    logic load;

    assign load = strobe & ~strobe_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b0;
            q        <= '0;
        end else begin
            strobe_d <= strobe;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/xcvr_path_sel.sv
`timescale 1ns/1ps
// Picks live or stored data, applies optional complement, gates by enable.
module xcvr_path_sel #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    input  logic             use_stored,
    input  logic             en,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] picked;
    logic [WIDTH-1:0] shaped;

    assign picked = use_stored ? stored : live;

    generate
        if (INVERT) begin : g_inv
            assign shaped = ~picked;
        end else begin : g_pass
            assign shaped = picked;
        end
    endgenerate

    assign y = en ? shaped : '0;
endmodule

// File: rtl/xcvr_drive_fsm.sv
`timescale 1ns/1ps
// Drive-mode controller with break-before-make turnaround.
module xcvr_drive_fsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);
    drive_e state_q;
    drive_e state_d;
    drive_e want;

    assign want = oe_n ? DRV_ISOLATE : (dir ? DRV_TO_B : DRV_TO_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DRV_ISOLATE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRV_ISOLATE: begin
                state_d = want;                 // enable_b / enable_a / hold
            end
            DRV_TO_B: begin
                if (want != DRV_TO_B) begin
                    state_d = DRV_ISOLATE;      // release / turnaround
                end
            end
            DRV_TO_A: begin
                if (want != DRV_TO_A) begin
                    state_d = DRV_ISOLATE;      // release / turnaround
                end
            end
            default: begin
                state_d = DRV_ISOLATE;
            end
        endcase
    end

    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (state_q)
            DRV_ISOLATE: ;
            DRV_TO_B:    b_oe = 1'b1;
            DRV_TO_A:    a_oe = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/reg_bus_xcvr.sv
`timescale 1ns/1ps
module reg_bus_xcvr #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             cpab,
    input  logic             cpba,
    input  logic             sab,
    input  logic             sba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic [WIDTH-1:0] ab_q;
    logic [WIDTH-1:0] ba_q;

    xcvr_rise_capture #(.WIDTH(WIDTH)) u_cap_ab (
        .clk(clk), .rst(rst), .strobe(cpab), .d(a_in), .q(ab_q)
    );

    xcvr_rise_capture #(.WIDTH(WIDTH)) u_cap_ba (
        .clk(clk), .rst(rst), .strobe(cpba), .d(b_in), .q(ba_q)
    );

    xcvr_drive_fsm u_fsm (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .a_oe(a_oe), .b_oe(b_oe)
    );

    xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
        .live(a_in), .stored(ab_q), .use_stored(sab), .en(b_oe), .y(b_out)
    );

    xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
        .live(b_in), .stored(ba_q), .use_stored(sba), .en(a_oe), .y(a_out)
    );
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             oe_n,
    input logic             cpab,
    input logic             cpba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             a_oe,
    input logic             b_oe,
    input logic [WIDTH-1:0] ab_q,
    input logic [WIDTH-1:0] ba_q
);
    logic cpab_d;
    logic cpba_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpab_d <= 1'b0;
            cpba_d <= 1'b0;
        end else begin
            cpab_d <= cpab;
            cpba_d <= cpba;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!a_oe && !b_oe && ab_q == '0 && ba_q == '0)); // R1
    AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpab && !cpab_d) |=> ab_q == $past(a_in)); // R2
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpab && !cpab_d) |=> $stable(ab_q)); // R2
    AST_BA_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpba && !cpba_d) |=> ba_q == $past(b_in)); // R3
    AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpba && !cpba_d) |=> $stable(ba_q)); // R3
    AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> (!a_oe && !b_oe)); // R5
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_oe, b_oe})); // R6
    AST_A_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
        a_oe |=> !b_oe); // R6
    AST_B_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
        b_oe |=> !a_oe); // R6
endmodule

bind reg_bus_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_xcvr_checker (
    .clk(clk), .rst(rst), .oe_n(oe_n), .cpab(cpab), .cpba(cpba),
    .a_in(a_in), .b_in(b_in), .a_oe(a_oe), .b_oe(b_oe),
    .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/test_reg_bus_xcvr.sv
`timescale 1ns/1ps
module test_reg_bus_xcvr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       oe_n = 1'b1, dir = 1'b0, cpab = 1'b0, cpba = 1'b0, sab = 1'b0, sba = 1'b0;
    logic [7:0] a_in = 8'h00, b_in = 8'h00;
    logic [7:0] a_out_p, b_out_p, a_out_i, b_out_i;
    logic       a_oe_p, b_oe_p, a_oe_i, b_oe_i;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "reset";

    // reference model state
    logic [7:0] m_ab = 8'h00, m_ba = 8'h00;
    logic       m_pab = 1'b0, m_pba = 1'b0;
    int         m_st = 0;      // 0 isolate, 1 B driven, 2 A driven

    always #2.5 clk = ~clk;

    reg_bus_xcvr #(.WIDTH(8), .INVERT(1'b0)) i_reg_bus_xcvr (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cpab(cpab), .cpba(cpba),
        .sab(sab), .sba(sba), .a_in(a_in), .b_in(b_in),
        .a_out(a_out_p), .a_oe(a_oe_p), .b_out(b_out_p), .b_oe(b_oe_p)
    );

    reg_bus_xcvr #(.WIDTH(8), .INVERT(1'b1)) i_reg_bus_xcvr_inv (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cpab(cpab), .cpba(cpba),
        .sab(sab), .sba(sba), .a_in(a_in), .b_in(b_in),
        .a_out(a_out_i), .a_oe(a_oe_i), .b_out(b_out_i), .b_oe(b_oe_i)
    );

    always @(posedge clk) begin
        int want;
        if (rst) begin
            m_ab = 8'h00; m_ba = 8'h00; m_pab = 1'b0; m_pba = 1'b0; m_st = 0;
        end else begin
            if (cpab && !m_pab) m_ab = a_in;
            if (cpba && !m_pba) m_ba = b_in;
            m_pab = cpab;
            m_pba = cpba;
            want = oe_n ? 0 : (dir ? 1 : 2);
            if (m_st != 0 && want != m_st) m_st = 0;
            else m_st = want;
        end
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s [%s] actual=%h expected=%h", req, what, phase, act, exp);
        end
    endtask

    task automatic compare_all();
        logic       eb, ea;
        logic [7:0] vb, va;
        eb = (m_st == 1);
        ea = (m_st == 2);
        vb = sab ? m_ab : a_in;
        va = sba ? m_ba : b_in;
        chk("R5", "b_oe", {7'b0, b_oe_p}, {7'b0, eb});
        chk("R5", "a_oe", {7'b0, a_oe_p}, {7'b0, ea});
        chk("R6", "single driver", {7'b0, a_oe_p & b_oe_p}, 8'h00);
        chk(eb ? "R7" : "R10", "b_out", b_out_p, eb ? vb : 8'h00);
        chk(ea ? "R8" : "R10", "a_out", a_out_p, ea ? va : 8'h00);
        chk("R9", "b_oe inv", {7'b0, b_oe_i}, {7'b0, eb});
        chk("R9", "a_oe inv", {7'b0, a_oe_i}, {7'b0, ea});
        chk("R9", "b_out inv", b_out_i, eb ? ~vb : 8'h00);
        chk("R9", "a_out inv", a_out_i, ea ? ~va : 8'h00);
    endtask

    // inputs are set just after a falling edge; compare 1 ns later
    task automatic cyc();
        #1 compare_all();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(5.0 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        phase = "R1 reset";
        oe_n = 1'b0; dir = 1'b1; sab = 1'b1; cpab = 1'b1; a_in = 8'h5a;
        cyc(); cyc();
        rst = 1'b0;
        oe_n = 1'b1; cpab = 1'b0;
        cyc();

        phase = "R2 R3 held strobe";
        oe_n = 1'b0; dir = 1'b1; sab = 1'b1;
        cpab = 1'b1; a_in = 8'h11; cyc();
        a_in = 8'h22; cyc();
        a_in = 8'h33; cyc();
        cpab = 1'b0; a_in = 8'h44; cyc();
        cpab = 1'b1; cyc();
        cpab = 1'b0; a_in = 8'h00; cyc();
        dir = 1'b0; sba = 1'b1;
        cpba = 1'b1; b_in = 8'h66; cyc();
        b_in = 8'h77; cyc(); cyc();
        cpba = 1'b0; cyc();

        phase = "R4 isolated capture";
        oe_n = 1'b1;
        cpab = 1'b1; cpba = 1'b1; a_in = 8'h3c; b_in = 8'hc3; cyc();
        cpab = 1'b0; cpba = 1'b0; a_in = 8'h00; b_in = 8'hff; cyc();
        oe_n = 1'b0; dir = 1'b1; sab = 1'b1; cyc(); cyc();
        dir = 1'b0; sba = 1'b1; cyc(); cyc(); cyc();

        phase = "R6 turnaround";
        for (int k = 0; k < 10; k++) begin
            dir = ~dir;
            a_in = 8'(k * 17);
            b_in = 8'(k * 29 + 3);
            cyc();
        end
        dir = 1'b1; cyc(); cyc();

        phase = "R7 R8 all control settings";
        for (int c = 0; c < 16; c++) begin
            {oe_n, dir, sab, sba} = 4'(c);
            for (int k = 0; k < 6; k++) begin
                a_in = 8'($urandom); b_in = 8'($urandom);
                cpab = 1'($urandom); cpba = 1'($urandom);
                cyc();
            end
        end

        phase = "random";
        for (int k = 0; k < 400; k++) begin
            rst = ($urandom % 50) == 0;
            {oe_n, dir, sab, sba, cpab, cpba} = 6'($urandom);
            a_in = 8'($urandom); b_in = 8'($urandom);
            cyc();
        end
        rst = 1'b0;
        cyc();

        summary();
        $finish;
    end
endmodule